// File: doc/BRIEF.md
# SCSI Transfer Length and Completion Sequencer

This block runs the transfer and selection commands of a SCSI initiator. A select command looks up the target named by the bus-ID field. It either reports that no such target exists, or it records how many bytes the target wants to move and in which direction. A transfer command then turns the programmed 16-bit count into a move length:

- A count of zero stands for 65536.
- The length is clamped to the target's outstanding data, or to a 32-byte window while a command is being captured.
- The block then counts down one byte for each accepted DMA beat.

On each outcome the block writes a fixed status / interrupt / sequence-step triple and raises its interrupt line. A host read-acknowledge lowers the interrupt line again.

A selection is only carried out while the DMA-enable input is high. If a selection arrives while it is low, the block parks the selection and runs it on the first clock edge that samples enable high.

The controller has four states:

- **IDLE**: accepts commands.
- **PEND**: a selection is waiting for enable. The transition PEND→IDLE happens on enable high.
- **MOVE**: bytes are being counted down. MOVE→IDLE happens on the last beat or on an aborting selection. MOVE→PEND happens on an aborting selection while enable is low.
- **ZERO**: one cycle taken by a transfer of length zero. ZERO→IDLE always.

From IDLE, a selection moves to PEND when enable is low. A transfer moves to MOVE when its length is nonzero, and to ZERO when its length is zero.

Top module: `xfer_seq_top`

## Requirements
- R1: After reset, `stat`, `intr`, `seq`, `count_q` and `remain` are 0, and `irq`, `busy` and `capture_mode` are low.
- R2: A transfer command (`cmd_op`=0) issued in IDLE loads `remain` with min(L, T) when capture mode is off. Here L is `count_q`, with `count_q`=0 meaning 65536, and T is the target data length recorded at the last successful selection.
- R3: While `capture_mode` is high, a transfer command loads `remain` with min(L, 32).
- R4: A count write (`cnt_wr`) and a transfer command both clear `stat` bit 4.
- R5: Each `beat_ack` in MOVE lowers `remain` by one. A `beat_ack` outside MOVE changes nothing.
- R6: On the beat that takes `remain` to zero, the block does all of the following: sets `stat` bit 4, `intr`=0x10, `seq`=0, `count_q`=0, clears `capture_mode`, raises `irq` and returns to IDLE. A transfer of length zero does the same one cycle after the command.
- R7: A selection whose target bit in `tgt_present` is 0 gives `stat`=0x00, `intr`=0x20, `seq`=0 and raises `irq`.
- R8: A successful plain selection (`cmd_op` 1 or 2) gives `intr`=0x18 and `seq`=4. `stat` becomes 0x11 for data-in (`tgt_dir_in`=1), 0x10 for data-out, and 0x00 when `tgt_len` is 0.
- R9: A successful select-and-stop (`cmd_op`=3) sets `capture_mode` and gives `stat`=0x12, `intr`=0x18 and `seq`=4.
- R10: A selection seen while `dma_en` is low puts the block in PEND with `busy` high and no code change. It then runs on the first edge that samples `dma_en` high.
- R11: A selection arriving in MOVE aborts the transfer and forces `remain` to 0.
- R12: A status command (`cmd_op`=4) in IDLE gives `stat`=0x17, `intr`=0x08 and `seq`=4, and raises `irq`.
- R13: `irq_ack` clears `irq`, `intr` and `stat` bit 4 and sets `seq`=4. A completion in the same cycle takes priority.
- R14: The target is the bit of `tgt_present` indexed by `bus_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Write strobe for the transfer count |
| cnt_wdata | input | 16 | Transfer count value |
| bus_id | input | 3 | Target number of the next selection |
| tgt_present | input | 8 | One bit per target, 1 = present |
| tgt_len | input | 17 | Bytes the selected target will move |
| tgt_dir_in | input | 1 | 1 = data-in, 0 = data-out |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command: 0 transfer, 1 select, 2 select-with-attention, 3 select-and-stop, 4 status; other values ignored |
| dma_en | input | 1 | DMA enable; low holds selections |
| beat_ack | input | 1 | One byte accepted by the DMA side |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| count_q | output | 16 | Current transfer count register |
| remain | output | 17 | Bytes still to move |
| busy | output | 1 | Controller outside IDLE |
| capture_mode | output | 1 | Command-capture mode active |
| stat | output | 8 | Status code |
| intr | output | 8 | Interrupt cause code |
| seq | output | 3 | Sequence step |
| irq | output | 1 | Interrupt line |

## Verification
A wrong state or a wrong counter value is visible at the next clock edge.

- A controller stuck in MOVE or PEND shows as `busy` staying high.
- A counter that skips or holds shows as `remain` departing from a one-per-beat staircase.
- A wrong clamp shows as a bad `remain` the cycle after the transfer command.
- A completion path that picks the wrong code triple shows as a mismatch on `stat`, `intr` or `seq` in the cycle after the triggering edge.

The table-driven part of the bench sweeps the length clamp, including the count-of-zero case. The directed part covers abort, deferral, capture and acknowledge collisions.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    localparam logic [2:0] OP_XFER     = 3'd0;
    localparam logic [2:0] OP_SEL      = 3'd1;
    localparam logic [2:0] OP_SEL_ATN  = 3'd2;
    localparam logic [2:0] OP_SEL_STOP = 3'd3;
    localparam logic [2:0] OP_STATUS   = 3'd4;

    localparam logic [7:0] INT_DONE = 8'h10;
    localparam logic [7:0] INT_SVC  = 8'h18;
    localparam logic [7:0] INT_GONE = 8'h20;
    localparam logic [7:0] INT_FC   = 8'h08;

    localparam logic [7:0] STA_STOP = 8'h12;
    localparam logic [7:0] STA_RESP = 8'h17;
    localparam logic [7:0] STA_TC   = 8'h10;

    localparam logic [2:0] SEQ_CMD  = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PEND,
        S_MOVE,
        S_ZERO
    } seq_state_e;

    function automatic logic is_select(input logic [2:0] op);
        return (op == OP_SEL) || (op == OP_SEL_ATN) || (op == OP_SEL_STOP);
    endfunction

endpackage

// File: rtl/xfer_len_calc.sv
module xfer_len_calc #(
    parameter int CNT_W = 16,
    parameter int CAP   = 32
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W:0]   tgt_left,
    input  logic             capture,
    output logic [CNT_W:0]   move_len
);
    localparam int LEN_W = CNT_W + 1;
    localparam logic [LEN_W-1:0] FULL  = LEN_W'(1) << CNT_W;
    localparam logic [LEN_W-1:0] CAP_L = LEN_W'(CAP);

    logic [LEN_W-1:0] prog_len;
    logic [LEN_W-1:0] limit;

    always_comb begin
        prog_len = (count == '0) ? FULL : {1'b0, count};
        limit    = capture ? CAP_L : tgt_left;
        move_len = (prog_len < limit) ? prog_len : limit;
    end
endmodule

// File: rtl/xfer_byte_ctr.sv
module xfer_byte_ctr #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && count != '0) begin
            count <= count - W'(1);
        end
    end

    assign last = (count == W'(1));
endmodule

// File: rtl/xfer_seq_top.sv
module xfer_seq_top
    import xfer_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CAP   = 32,
    parameter int ID_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_wr,
    input  logic [CNT_W-1:0]     cnt_wdata,
    input  logic [ID_W-1:0]      bus_id,
    input  logic [(1<<ID_W)-1:0] tgt_present,
    input  logic [CNT_W:0]       tgt_len,
    input  logic                 tgt_dir_in,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic                 dma_en,
    input  logic                 beat_ack,
    input  logic                 irq_ack,
    output logic [CNT_W-1:0]     count_q,
    output logic [CNT_W:0]       remain,
    output logic                 busy,
    output logic                 capture_mode,
    output logic [7:0]           stat,
    output logic [7:0]           intr,
    output logic [2:0]           seq,
    output logic                 irq
);
    localparam int LEN_W = CNT_W + 1;

    seq_state_e       state, nstate;
    logic [LEN_W-1:0] tgt_left;
    logic [LEN_W-1:0] move_len;
    logic [2:0]       pend_op;
    logic [2:0]       run_op;
    logic             ctr_last;

    logic in_ready, sel_req, sel_fire, sel_park;
    logic xfer_go, resp_go, beat_take, move_done;

    logic [7:0] sel_stat, sel_intr;
    logic [2:0] sel_seq;
    logic       sel_cap, sel_hit;

    // Command decode
    always_comb begin
        in_ready  = (state == S_IDLE) || (state == S_MOVE);
        sel_req   = cmd_valid && is_select(cmd_op) && in_ready;
        sel_fire  = ((state == S_PEND) && dma_en) || (sel_req && dma_en);
        sel_park  = sel_req && !dma_en;
        xfer_go   = (state == S_IDLE) && cmd_valid && (cmd_op == OP_XFER);
        resp_go   = (state == S_IDLE) && cmd_valid && (cmd_op == OP_STATUS);
        beat_take = (state == S_MOVE) && beat_ack && !sel_req;
        move_done = (beat_take && ctr_last) || (state == S_ZERO);
    end

    xfer_len_calc #(
        .CNT_W (CNT_W),
        .CAP   (CAP)
    ) i_len (
        .count    (count_q),
        .tgt_left (tgt_left),
        .capture  (capture_mode),
        .move_len (move_len)
    );

    xfer_byte_ctr #(
        .W (LEN_W)
    ) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (xfer_go),
        .load_val (move_len),
        .dec      (beat_take),
        .clr      (sel_req),
        .count    (remain),
        .last     (ctr_last)
    );

    // Selection outcome codes
    always_comb begin
        run_op   = (state == S_PEND) ? pend_op : cmd_op;
        sel_hit  = tgt_present[bus_id];
        sel_stat = 8'h00;
        sel_intr = INT_SVC;
        sel_seq  = SEQ_CMD;
        sel_cap  = 1'b0;
        if (!sel_hit) begin
            sel_intr = INT_GONE;
            sel_seq  = 3'd0;
        end else if (run_op == OP_SEL_STOP) begin
            sel_stat = STA_STOP;
            sel_cap  = 1'b1;
        end else if (tgt_len != '0) begin
            sel_stat = STA_TC | {7'd0, tgt_dir_in};
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (sel_park) begin
                    nstate = S_PEND;
                end else if (xfer_go) begin
                    nstate = (move_len == '0) ? S_ZERO : S_MOVE;
                end
            end
            S_PEND: begin
                if (dma_en) nstate = S_IDLE;
            end
            S_MOVE: begin
                if (sel_req) begin
                    nstate = dma_en ? S_IDLE : S_PEND;
                end else if (beat_take && ctr_last) begin
                    nstate = S_IDLE;
                end
            end
            S_ZERO: nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    assign busy = (state != S_IDLE);

    // Outputs and completion registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat         <= 8'h00;
            intr         <= 8'h00;
            seq          <= 3'd0;
            irq          <= 1'b0;
            count_q      <= '0;
            tgt_left     <= '0;
            capture_mode <= 1'b0;
            pend_op      <= 3'd0;
        end else begin
            if (irq_ack) begin
                intr    <= 8'h00;
                stat[4] <= 1'b0;
                seq     <= SEQ_CMD;
                irq     <= 1'b0;
            end
            if (cnt_wr) begin
                count_q <= cnt_wdata;
                stat[4] <= 1'b0;
            end
            if (xfer_go) begin
                stat[4] <= 1'b0;
            end
            if (sel_park) begin
                pend_op <= cmd_op;
            end
            if (beat_take && !capture_mode) begin
                tgt_left <= tgt_left - LEN_W'(1);
            end
            if (resp_go) begin
                stat <= STA_RESP;
                intr <= INT_FC;
                seq  <= SEQ_CMD;
                irq  <= 1'b1;
            end
            if (sel_fire) begin
                stat         <= sel_stat;
                intr         <= sel_intr;
                seq          <= sel_seq;
                capture_mode <= sel_cap;
                irq          <= 1'b1;
                if (sel_hit) begin
                    tgt_left <= tgt_len;
                end
            end
            if (move_done) begin
                stat[4]      <= 1'b1;
                intr         <= INT_DONE;
                seq          <= 3'd0;
                count_q      <= '0;
                capture_mode <= 1'b0;
                irq          <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk
    import xfer_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CAP   = 32,
    parameter int ID_W  = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cnt_wr,
    input logic [CNT_W-1:0]     cnt_wdata,
    input logic [ID_W-1:0]      bus_id,
    input logic [(1<<ID_W)-1:0] tgt_present,
    input logic [CNT_W:0]       tgt_len,
    input logic                 tgt_dir_in,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_op,
    input logic                 dma_en,
    input logic                 beat_ack,
    input logic                 irq_ack,
    input logic [CNT_W-1:0]     count_q,
    input logic [CNT_W:0]       remain,
    input logic                 busy,
    input logic                 capture_mode,
    input logic [7:0]           stat,
    input logic [7:0]           intr,
    input logic [2:0]           seq,
    input logic                 irq
);
    localparam int LEN_W = CNT_W + 1;
    localparam logic [LEN_W-1:0] FULL  = LEN_W'(1) << CNT_W;
    localparam logic [LEN_W-1:0] CAP_L = LEN_W'(CAP);

    p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= FULL);

    p_cap_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture_mode |-> remain <= CAP_L);

    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat_ack && remain > LEN_W'(1) && !cmd_valid)
        |=> remain == $past(remain) - LEN_W'(1));

    p_done_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat_ack && remain == LEN_W'(1) && !cmd_valid)
        |=> (irq && intr == INT_DONE && seq == 3'd0 && count_q == '0
             && !busy && !capture_mode && stat[4]));

    p_stop_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capture_mode) |-> (stat == STA_STOP && intr == INT_SVC && seq == SEQ_CMD));

    p_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && is_select(cmd_op) && !dma_en) |=> busy);

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && is_select(cmd_op)) |=> remain == '0);

    p_irq_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> intr != 8'h00);
endmodule

bind xfer_seq_top xfer_seq_chk #(
    .CNT_W (CNT_W),
    .CAP   (CAP),
    .ID_W  (ID_W)
) i_xfer_seq_chk (.*);

// File: tb/test_xfer_seq_top.sv
module test_xfer_seq_top;
    localparam logic [2:0] C_XFER = 3'd0;
    localparam logic [2:0] C_SEL  = 3'd1;
    localparam logic [2:0] C_SELA = 3'd2;
    localparam logic [2:0] C_STOP = 3'd3;
    localparam logic [2:0] C_RESP = 3'd4;

    // Length-clamp vectors: programmed count, target length, expected remain
    localparam int NV = 7;
    localparam int V_CNT [NV] = '{5, 10, 0, 0, 256, 1, 258};
    localparam int V_TL  [NV] = '{10, 5, 70000, 300, 1000, 0, 258};
    localparam int V_EXP [NV] = '{5, 5, 65536, 300, 256, 0, 258};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic [2:0]  bus_id = 3'd3;
    logic [7:0]  tgt_present = 8'hFB;
    logic [16:0] tgt_len = '0;
    logic        tgt_dir_in = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic        dma_en = 1'b1;
    logic        beat_ack = 1'b0;
    logic        irq_ack = 1'b0;
    logic [15:0] count_q;
    logic [16:0] remain;
    logic        busy, capture_mode, irq;
    logic [7:0]  stat, intr;
    logic [2:0]  seq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    xfer_seq_top i_xfer_seq_top (.*);

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wr_count(input int v);
        @(negedge clk);
        cnt_wr    = 1'b1;
        cnt_wdata = 16'(v);
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic beat(input logic with_ack);
        @(negedge clk);
        beat_ack = 1'b1;
        irq_ack  = with_ack;
        @(negedge clk);
        beat_ack = 1'b0;
        irq_ack  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 stat", stat, 0);
        chk("R1 intr", intr, 0);
        chk("R1 seq", seq, 0);
        chk("R1 irq", irq, 0);
        chk("R1 busy", busy, 0);
        chk("R1 remain", remain, 0);
        chk("R1 count", count_q, 0);
        chk("R1 capture", capture_mode, 0);

        // R7 / R14: bus_id 2 indexes a missing target
        bus_id = 3'd2;
        tgt_len = 17'd9;
        issue(C_SEL);
        chk("R7 stat", stat, 8'h00);
        chk("R7 intr", intr, 8'h20);
        chk("R7 seq", seq, 0);
        chk("R7 irq", irq, 1);
        bus_id = 3'd3;
        ack();

        // R2 / R11 table sweep
        for (int i = 0; i < NV; i++) begin
            tgt_len = 17'(V_TL[i]);
            tgt_dir_in = 1'b1;
            issue(C_SEL);
            chk("R14 sel hit intr", intr, 8'h18);
            wr_count(V_CNT[i]);
            issue(C_XFER);
            chk("R2 remain", remain, V_EXP[i]);
            if (V_EXP[i] != 0) begin
                chk("R2 busy", busy, 1);
                tgt_len = '0;
                issue(C_SEL);
                chk("R11 remain", remain, 0);
                chk("R11 busy", busy, 0);
            end else begin
                @(negedge clk);
                chk("R6 zero done busy", busy, 0);
            end
            ack();
        end

        // R8 data-in select, R5 beats, R6 completion
        tgt_len = 17'd3;
        tgt_dir_in = 1'b1;
        issue(C_SEL);
        chk("R8 stat in", stat, 8'h11);
        chk("R8 intr", intr, 8'h18);
        chk("R8 seq", seq, 4);
        ack();
        chk("R13 irq", irq, 0);
        chk("R13 intr", intr, 0);
        chk("R13 stat", stat, 8'h01);
        chk("R13 seq", seq, 4);
        wr_count(3);
        issue(C_XFER);
        chk("R2 remain 3", remain, 3);
        beat(1'b0);
        chk("R5 remain 2", remain, 2);
        @(negedge clk);
        chk("R5 hold", remain, 2);
        beat(1'b0);
        chk("R5 remain 1", remain, 1);
        beat(1'b0);
        chk("R6 stat", stat, 8'h11);
        chk("R6 intr", intr, 8'h10);
        chk("R6 seq", seq, 0);
        chk("R6 irq", irq, 1);
        chk("R6 count", count_q, 0);
        chk("R6 busy", busy, 0);
        chk("R6 remain", remain, 0);

        // R5 beat while idle ignored
        beat(1'b0);
        chk("R5 idle remain", remain, 0);
        chk("R5 idle busy", busy, 0);
        chk("R5 idle intr", intr, 8'h10);

        // R6 zero-length move: target data used up
        ack();
        wr_count(4);
        issue(C_XFER);
        chk("R6 zero busy", busy, 1);
        chk("R6 zero remain", remain, 0);
        chk("R4 xfer clears tc", stat, 8'h01);
        chk("R6 zero irq early", irq, 0);
        @(negedge clk);
        chk("R6 zero irq", irq, 1);
        chk("R6 zero intr", intr, 8'h10);
        chk("R6 zero stat", stat, 8'h11);

        // R8 data-out with no data
        ack();
        tgt_len = '0;
        tgt_dir_in = 1'b0;
        issue(C_SELA);
        chk("R8 stat none", stat, 8'h00);
        chk("R8 intr atn", intr, 8'h18);
        ack();
        tgt_len = 17'd6;
        issue(C_SEL);
        chk("R8 stat out", stat, 8'h10);
        ack();

        // R9 capture, R3 window, R13 collision
        tgt_len = 17'd50;
        issue(C_STOP);
        chk("R9 capture", capture_mode, 1);
        chk("R9 stat", stat, 8'h12);
        chk("R9 intr", intr, 8'h18);
        chk("R9 seq", seq, 4);
        ack();
        wr_count(100);
        issue(C_XFER);
        chk("R3 remain", remain, 32);
        chk("R4 stat", stat, 8'h02);
        for (int k = 0; k < 31; k++) beat(1'b0);
        chk("R3 remain 1", remain, 1);
        beat(1'b1);
        chk("R13 done wins irq", irq, 1);
        chk("R13 done wins intr", intr, 8'h10);
        chk("R9 capture off", capture_mode, 0);
        chk("R6 stat cap", stat, 8'h12);
        wr_count(5);
        chk("R4 cnt_wr clears", stat, 8'h02);
        chk("R4 count", count_q, 5);

        // R10 deferral
        ack();
        dma_en = 1'b0;
        tgt_len = 17'd7;
        tgt_dir_in = 1'b1;
        issue(C_SEL);
        chk("R10 busy", busy, 1);
        chk("R10 irq", irq, 0);
        chk("R10 intr", intr, 0);
        @(negedge clk);
        @(negedge clk);
        chk("R10 still", busy, 1);
        dma_en = 1'b1;
        @(negedge clk);
        chk("R10 run busy", busy, 0);
        chk("R10 run stat", stat, 8'h11);
        chk("R10 run intr", intr, 8'h18);
        chk("R10 run irq", irq, 1);

        // R12 status command
        ack();
        issue(C_RESP);
        chk("R12 stat", stat, 8'h17);
        chk("R12 intr", intr, 8'h08);
        chk("R12 seq", seq, 4);
        chk("R12 irq", irq, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule